// File: doc/BRIEF.md
# Direction-Gated Odometer Counter

This block counts wheel pulses from two odometer inputs. Each input has its own 16-bit up/down counter, and both counters share one driving-state line. A host command bit decides how that line is used. When the bit is set, the state level picks the counting direction: high counts up and low counts down. When the bit is clear, the state line is ignored and both counters count up. The bit is clear after reset.

A periodic strobe from the shared timing divider copies both running counts into holding registers. The same strobe copies the synchronized driving state into a one-bit status register. The host reads the held values, the status bit and the command bit through a small registered read port. Before use, the pulse and state inputs pass through a two-flop synchronizer. A count step happens only on a rising edge of a synchronized pulse. The step direction comes from the state value in that same cycle.

Top module: `odo_counter_top`

## Requirements
- R1: After reset, both running counts, both held counts, the held state bit and the direction-enable bit are zero.
- R2: When the direction-enable bit is 0, each rising edge on a pulse input adds one to that channel's count, whatever the state input shows.
- R3: When the direction-enable bit is 1 and the state input is 1, each rising pulse edge adds one to that channel's count.
- R4: When the direction-enable bit is 1 and the state input is 0, each rising pulse edge subtracts one from that channel's count.
- R5: Counts wrap modulo 2^16: a step down from 0x0000 gives 0xFFFF, and a step up from 0xFFFF gives 0x0000.
- R6: A one-cycle `latch_strobe` copies every channel's count and the synchronized state into holding registers. Between strobes, the held values do not change, even when pulses arrive or the state line changes.
- R7: When `rd_en` is high on a clock edge, `rd_data` and `rd_valid=1` appear after that edge. Address 0 returns held count 0. Address 1 returns held count 1. Address 2 returns the held state in bit 0. Address 3 returns the direction-enable bit in bit 0. All other bits read as zero.
- R8: A `cmd_we` cycle loads `cmd_dir_en` into the direction-enable bit. A change of this bit leaves the counts unchanged and takes effect from the next pulse edge.
- R9: The channels count independently. A pulse input held high for many cycles counts exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_in | input | 2 | Asynchronous wheel-pulse inputs, one per channel |
| state_in | input | 1 | Asynchronous driving-state line shared by the channels |
| cmd_we | input | 1 | Write strobe for the direction-enable bit |
| cmd_dir_en | input | 1 | New value of the direction-enable bit |
| latch_strobe | input | 1 | One-cycle capture strobe from the divider |
| rd_en | input | 1 | Read request |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Registered read data |
| rd_valid | output | 1 | High in the cycle after a read request |

## Verification
The bench sweeps every combination of the enable bit and the state level, over several pulse counts on each channel alone and on both together. It compares the held values with an arithmetic model; a design that got the direction choice wrong would drift in one of the four modes. Wrap is tested by stepping down from zero and then back up. A design that saturates or sign-extends would return 0x0000 or a wrong width there. Further checks cover a long-held pulse, which a level-sensitive design would count many times, and held values after pulses and a state change, which a transparent latch would leak. A final check confirms that toggling the enable bit leaves the counts unchanged.

// File: rtl/odo_pkg.sv
package odo_pkg;
  localparam int unsigned ODO_SYNC_DEPTH = 2;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } odo_dir_e;
endpackage

// File: rtl/odo_sync.sv
module odo_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/odo_edge_counter.sv
module odo_edge_counter
  import odo_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pulse_s,
  input  odo_dir_e         dir,
  output logic [CNT_W-1:0] count
);
  logic pulse_d;
  logic rise;

  assign rise = pulse_s & ~pulse_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_d <= 1'b0;
      count   <= '0;
    end else begin
      pulse_d <= pulse_s;
      if (rise) begin
        if (dir == DIR_UP) count <= count + CNT_W'(1);
        else               count <= count - CNT_W'(1);
      end
    end
  end

  p_step_up_r3: assert property (@(posedge clk) disable iff (rst)
    (rise && dir == DIR_UP) |=> (count == $past(count) + CNT_W'(1)));

  p_step_down_r4: assert property (@(posedge clk) disable iff (rst)
    (rise && dir == DIR_DOWN) |=> (count == $past(count) - CNT_W'(1)));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!rise) |=> $stable(count));
endmodule

// File: rtl/odo_counter_top.sv
module odo_counter_top
  import odo_pkg::*;
#(
  parameter int unsigned NCH    = 2,
  parameter int unsigned CNT_W  = 16,
  localparam int unsigned ADDR_W = $clog2(NCH + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    pulse_in,
  input  logic              state_in,
  input  logic              cmd_we,
  input  logic              cmd_dir_en,
  input  logic              latch_strobe,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic              rd_valid
);
  localparam int unsigned SYNC_W = NCH + 1;
  localparam int unsigned STATE_SLOT = NCH;
  localparam int unsigned EN_SLOT    = NCH + 1;

  logic [SYNC_W-1:0] sync_q;
  logic [NCH-1:0]    pulse_s;
  logic              state_s;
  logic              dir_en_q;
  odo_dir_e          dir;
  logic [CNT_W-1:0]  cnt  [NCH];
  logic [CNT_W-1:0]  held [NCH];
  logic              held_state;
  logic [CNT_W-1:0]  rd_mux;

  odo_sync #(.W(SYNC_W), .STAGES(ODO_SYNC_DEPTH)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({state_in, pulse_in}),
    .q   (sync_q)
  );

  assign pulse_s = sync_q[NCH-1:0];
  assign state_s = sync_q[NCH];

  always_ff @(posedge clk) begin
    if (rst)         dir_en_q <= 1'b0;
    else if (cmd_we) dir_en_q <= cmd_dir_en;
  end

  assign dir = (!dir_en_q || state_s) ? DIR_UP : DIR_DOWN;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    odo_edge_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .pulse_s (pulse_s[c]),
      .dir     (dir),
      .count   (cnt[c])
    );

    always_ff @(posedge clk) begin
      if (rst)               held[c] <= '0;
      else if (latch_strobe) held[c] <= cnt[c];
    end

    p_capture_r6: assert property (@(posedge clk) disable iff (rst)
      latch_strobe |=> (held[c] == $past(cnt[c])));

    p_keep_r6: assert property (@(posedge clk) disable iff (rst)
      !latch_strobe |=> $stable(held[c]));
  end

  always_ff @(posedge clk) begin
    if (rst)               held_state <= 1'b0;
    else if (latch_strobe) held_state <= state_s;
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NCH; i++)
      if (rd_addr == ADDR_W'(i)) rd_mux = held[i];
    if (rd_addr == ADDR_W'(STATE_SLOT)) rd_mux = CNT_W'(held_state);
    if (rd_addr == ADDR_W'(EN_SLOT))    rd_mux = CNT_W'(dir_en_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end

  p_rd_valid_r7: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  p_en_write_r8: assert property (@(posedge clk) disable iff (rst)
    cmd_we |=> (dir_en_q == $past(cmd_dir_en)));

  p_en_keep_r8: assert property (@(posedge clk) disable iff (rst)
    !cmd_we |=> $stable(dir_en_q));
endmodule

// File: tb/sim_odo_counter_top.sv
module sim_odo_counter_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  pulse_in = '0;
  logic        state_in = 1'b0;
  logic        cmd_we = 1'b0;
  logic        cmd_dir_en = 1'b0;
  logic        latch_strobe = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        rd_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit en_m   = 1'b0;
  logic [15:0] exp_cnt [2];
  logic [15:0] got;

  always #5 clk = ~clk;

  odo_counter_top u0 (
    .clk(clk), .rst(rst), .pulse_in(pulse_in), .state_in(state_in),
    .cmd_we(cmd_we), .cmd_dir_en(cmd_dir_en), .latch_strobe(latch_strobe),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; cycles(3); rst = 1'b0; cycles(1);
    en_m = 1'b0; exp_cnt[0] = '0; exp_cnt[1] = '0;
  endtask

  task automatic read(input logic [1:0] a, output logic [15:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    checks++;
    if (rd_valid !== 1'b1) begin
      fails++;
      $display("FAIL R7: rd_valid actual %b expected 1", rd_valid);
    end
    d = rd_data;
  endtask

  task automatic latch();
    latch_strobe = 1'b1; @(negedge clk); latch_strobe = 1'b0; cycles(1);
  endtask

  task automatic set_en(input bit v);
    cmd_we = 1'b1; cmd_dir_en = v; @(negedge clk); cmd_we = 1'b0; en_m = v;
  endtask

  task automatic set_state(input bit v);
    state_in = v; cycles(4);
  endtask

  task automatic pulse(input logic [1:0] mask, input int hold);
    pulse_in = mask; cycles(hold); pulse_in = '0; cycles(4);
    for (int c = 0; c < 2; c++)
      if (mask[c]) begin
        if (!en_m || state_in) exp_cnt[c] = exp_cnt[c] + 16'd1;
        else                   exp_cnt[c] = exp_cnt[c] - 16'd1;
      end
  endtask

  task automatic compare_counts(input string req);
    latch();
    read(2'd0, got); check(req, got, exp_cnt[0]);
    read(2'd1, got); check(req, got, exp_cnt[1]);
  endtask

  initial begin
    logic [15:0] snap0;
    do_reset();
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      read(2'(a), got); check("R1", got, 16'h0000);
    end
    // R2/R3/R4/R9 sweep over enable and state
    for (int m = 0; m < 4; m++) begin
      set_en(m[1]);
      set_state(m[0]);
      for (int n = 0; n < 4; n++) begin
        for (int k = 0; k < n; k++) pulse(2'b01, 4);
        pulse(2'b11, 4);
        for (int k = 0; k < (n + 1) % 3; k++) pulse(2'b10, 4);
        if (!m[1])     compare_counts("R2");
        else if (m[0]) compare_counts("R3");
        else           compare_counts("R4");
        read(2'd2, got); check("R6 state", got, {15'd0, m[0]});
      end
    end
    // R9 long-held pulse counts once
    pulse(2'b01, 40);
    compare_counts("R9");
    // R6 held values stay between strobes
    set_en(1'b1); set_state(1'b1);
    latch();
    snap0 = exp_cnt[0];
    pulse(2'b01, 4); pulse(2'b01, 4);
    set_state(1'b0);
    read(2'd0, got); check("R6", got, snap0);
    read(2'd2, got); check("R6", got, 16'h0001);
    compare_counts("R6");
    // R8 enable readback and no count disturbance
    set_en(1'b0);
    read(2'd3, got); check("R8", got, 16'h0000);
    compare_counts("R8");
    set_en(1'b1);
    read(2'd3, got); check("R7", got, 16'h0001);
    compare_counts("R8");
    // R5 wrap both directions
    do_reset();
    set_en(1'b1); set_state(1'b0);
    pulse(2'b01, 4);
    compare_counts("R5");
    check("R5 down", exp_cnt[0], 16'hFFFF);
    set_state(1'b1);
    pulse(2'b01, 4);
    compare_counts("R5");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule